// File: doc/BRIEF.md
# Embedded Core Boot Sequencer

This controller brings up a small embedded processor whose code and data memories are loaded through a mailbox of 16-bit registers. On a start pulse it checks that both section sizes are whole words. It then stalls the processor and copies two sections from a word source into the processor's memories, data memory first and instruction memory second. The word source is addressed by byte offset. Each 32-bit word goes into the mailbox as a high half and a low half, followed by a write-execute command.

After each section the controller reads back the CRC that the mailbox accumulated. It compares that value with a CRC-16 (polynomial 0x1021, initial value zero) that it computes itself over the word bytes, most significant byte first. If both sections match, it clears the soft-reset and low-power controls. It then holds the processor in reset for a timed interval and finally lets it run. The run ends with a one-cycle done pulse and an error code.

Register selects used on `reg_sel`:
- 0: processor control. Bit 0 is run-stall, bit 1 is stall-override, bit 2 is processor reset.
- 1: mailbox command. Value 0x0001 clears the CRC; value 0x0006 is write plus execute.
- 2 and 3: the high and low halves of the target address.
- 4 and 5: the high and low halves of the data word.
- 6: global control. Writing 0x0000 clears soft-reset and low-power.
- 7: the mailbox CRC, which is read only.

Top module: `boot_seq`

## Requirements
- R1: After reset there is no register write or read, no source request, `done` is low and `err` is 0.
- R2: On an accepted start, a data size that is not a multiple of 4 ends the run with `err`=1, and otherwise an unaligned instruction size ends it with `err`=2. In both cases `done` pulses and no register write takes place.
- R3: The first write of a valid run is processor control (select 0) with value 0x0003, meaning run-stall and stall-override.
- R4: Each section begins with a CRC-clear command (select 1, value 0x0001), then address high (select 2), then address low (select 3). The data section uses base 0x3FFE0000 and comes first; the instruction section uses base 0x40000000 and comes second.
- R5: Word k of a section is fetched from byte offset base_offset+4k. Its bits 31:16 are written to select 4, then its bits 15:0 to select 5, then command 0x0006 is written to select 1.
- R6: After a section, the mailbox CRC is read and compared with the local CRC. A mismatch ends the run with `err`=3 for the data section or `err`=4 for the instruction section, with no further write, so the processor is never released.
- R7: After both sections match, the controller writes select 6 with 0x0000 and then select 0 with 0x0007.
- R8: The final write, select 0 with value 0x0002, comes exactly CLK_MHZ*HOLD_US cycles after the 0x0007 write, and no write occurs in between.
- R9: `done` is high for exactly one cycle at the end of every run, with `err`=0 on success, and a new start is then accepted.
- R10: A start pulse while a run is in progress has no effect. Offsets and sizes are sampled only when a start is accepted.
- R11: A zero-size section streams no words and expects a mailbox CRC of 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| dm_offset | input | OFF_W | Byte offset of the data section in the source |
| dm_bytes | input | OFF_W | Data section size in bytes |
| im_offset | input | OFF_W | Byte offset of the instruction section |
| im_bytes | input | OFF_W | Instruction section size in bytes |
| src_req | output | 1 | Word request, held until `src_valid` |
| src_addr | output | OFF_W | Byte offset of the requested word |
| src_valid | input | 1 | Requested word present on `src_word` |
| src_word | input | 32 | Word from the source |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Mailbox CRC read strobe (one cycle) |
| reg_sel | output | 3 | Register select |
| reg_wdata | output | 16 | Write data |
| rd_valid | input | 1 | Read data present on `rd_data` |
| rd_data | input | 16 | Mailbox CRC value |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 3 | Result code, valid with `done` and held until the next start |

## Verification
The hardest situations to reach are a CRC failure on the second section after the first has matched, and an unexpected release of the processor after a failure. The bench's mailbox model returns the CRC it computes from its own memory image. It flips one bit of that value only for the section chosen by each test, which forces a late mismatch after a full correct data load. A zero-length instruction section and a start pulse carrying bad sizes in the middle of a run cover the remaining corners.

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int          OFF_W   = 24,
  parameter int          CLK_MHZ = 125,
  parameter int          HOLD_US = 100,
  parameter logic [31:0] DM_BASE = 32'h3FFE_0000,
  parameter logic [31:0] IM_BASE = 32'h4000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OFF_W-1:0] dm_offset,
  input  logic [OFF_W-1:0] dm_bytes,
  input  logic [OFF_W-1:0] im_offset,
  input  logic [OFF_W-1:0] im_bytes,
  output logic             src_req,
  output logic [OFF_W-1:0] src_addr,
  input  logic             src_valid,
  input  logic [31:0]      src_word,
  output logic             reg_wr,
  output logic             reg_rd,
  output logic [2:0]       reg_sel,
  output logic [15:0]      reg_wdata,
  input  logic             rd_valid,
  input  logic [15:0]      rd_data,
  output logic             done,
  output logic [2:0]       err
);
  localparam int HOLD_CYC = CLK_MHZ * HOLD_US;
  localparam int TW = $clog2(HOLD_CYC + 1);
  localparam int CW = OFF_W - 2;
  localparam logic [TW-1:0] TLAST = TW'(HOLD_CYC - 2);
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_STALL, S_CRST, S_AHI, S_ALO, S_FETCH, S_DHI, S_DLO,
    S_EXEC, S_RDCRC, S_WCRC, S_CLR, S_HOLD, S_WAIT, S_REL, S_DONE
  } st_t;

  st_t             st;
  logic            sec;
  logic [CW-1:0]   cnt, dm_w, im_w;
  logic [OFF_W-1:0] dm_o, im_o;
  logic [31:0]     word;
  logic [15:0]     crc;
  logic [TW-1:0]   tmr;

  function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [31:0] w);
    logic [15:0] r;
    r = c;
    for (int i = 31; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ w[i]) ? 16'h1021 : 16'h0000);
    return r;
  endfunction

  wire [CW-1:0]    words = sec ? im_w : dm_w;
  wire [31:0]      base  = sec ? IM_BASE : DM_BASE;
  wire [OFF_W-1:0] off   = sec ? im_o : dm_o;

  assign src_req  = (st == S_FETCH);
  assign src_addr = off + {cnt, 2'b00};
  assign reg_rd   = (st == S_RDCRC);
  assign done     = (st == S_DONE);

  always_comb begin
    reg_wr    = 1'b1;
    reg_sel   = 3'd0;
    reg_wdata = 16'h0000;
    case (st)
      S_STALL: begin reg_sel = 3'd0; reg_wdata = 16'h0003; end
      S_CRST:  begin reg_sel = 3'd1; reg_wdata = 16'h0001; end
      S_AHI:   begin reg_sel = 3'd2; reg_wdata = base[31:16]; end
      S_ALO:   begin reg_sel = 3'd3; reg_wdata = base[15:0]; end
      S_DHI:   begin reg_sel = 3'd4; reg_wdata = word[31:16]; end
      S_DLO:   begin reg_sel = 3'd5; reg_wdata = word[15:0]; end
      S_EXEC:  begin reg_sel = 3'd1; reg_wdata = 16'h0006; end
      S_CLR:   begin reg_sel = 3'd6; reg_wdata = 16'h0000; end
      S_HOLD:  begin reg_sel = 3'd0; reg_wdata = 16'h0007; end
      S_REL:   begin reg_sel = 3'd0; reg_wdata = 16'h0002; end
      S_RDCRC: begin reg_wr = 1'b0; reg_sel = 3'd7; end
      default: reg_wr = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sec  <= 1'b0;
      cnt  <= '0;
      dm_w <= '0;
      im_w <= '0;
      dm_o <= '0;
      im_o <= '0;
      word <= '0;
      crc  <= '0;
      tmr  <= '0;
      err  <= 3'd0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          err  <= 3'd0;
          sec  <= 1'b0;
          dm_w <= dm_bytes[OFF_W-1:2];
          im_w <= im_bytes[OFF_W-1:2];
          dm_o <= dm_offset;
          im_o <= im_offset;
          if (dm_bytes[1:0] != 2'b00)      begin err <= 3'd1; st <= S_DONE; end
          else if (im_bytes[1:0] != 2'b00) begin err <= 3'd2; st <= S_DONE; end
          else st <= S_STALL;
        end
        S_STALL: st <= S_CRST;
        S_CRST:  begin crc <= '0; st <= S_AHI; end
        S_AHI:   st <= S_ALO;
        S_ALO:   begin cnt <= '0; st <= (words == '0) ? S_RDCRC : S_FETCH; end
        S_FETCH: if (src_valid) begin word <= src_word; st <= S_DHI; end
        S_DHI:   st <= S_DLO;
        S_DLO:   st <= S_EXEC;
        S_EXEC: begin
          crc <= crc_word(crc, word);
          cnt <= cnt + ONE;
          st  <= (cnt + ONE == words) ? S_RDCRC : S_FETCH;
        end
        S_RDCRC: st <= S_WCRC;
        S_WCRC: if (rd_valid) begin
          if (rd_data != crc) begin
            err <= sec ? 3'd4 : 3'd3;
            st  <= S_DONE;
          end else if (!sec) begin
            sec <= 1'b1;
            st  <= S_CRST;
          end else st <= S_CLR;
        end
        S_CLR:  st <= S_HOLD;
        S_HOLD: begin tmr <= '0; st <= S_WAIT; end
        S_WAIT: if (tmr == TLAST) st <= S_REL; else tmr <= tmr + 1'b1;
        S_REL:  st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fetch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && !src_valid) |=> (src_req && $stable(src_addr)));

  p_err_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err != $past(err)) |-> (done || err == 3'd0));

  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd0 && reg_wdata == 16'h0007) |=> !reg_wr);

  p_no_rd_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> (!reg_wr && !src_req));
endmodule

// File: tb/boot_seq_test.sv
module boot_seq_test;
  localparam int MHZ  = 2;
  localparam int HOLD = MHZ * 100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] dm_offset = '0, dm_bytes = '0, im_offset = '0, im_bytes = '0;
  logic src_req, src_valid = 1'b0;
  logic [23:0] src_addr;
  logic [31:0] src_word = '0;
  logic reg_wr, reg_rd, rd_valid = 1'b0, done;
  logic [2:0] reg_sel, err;
  logic [15:0] reg_wdata, rd_data = '0;

  boot_seq #(.CLK_MHZ(MHZ)) uut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, hold_start = 0, sec_seen = 0, corrupt_sec = -1;
  int done_seen = 0;
  bit finished = 0, lat = 0, rd_pend = 0;
  logic [2:0] err_seen;
  logic [15:0] sec_crc [2];
  logic [31:0] mem [256];
  logic [18:0] expq [$];
  string tagq [$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_bytes(logic [15:0] c, logic [31:0] w);
    for (int b = 3; b >= 0; b--) begin
      c ^= {w[8*b +: 8], 8'h00};
      for (int i = 0; i < 8; i++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic push(logic [2:0] s, logic [15:0] d, string t);
    expq.push_back({s, d});
    tagq.push_back(t);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (reg_wr) begin
        if (expq.size() == 0) chk(0, "R6 unexpected write", {reg_sel, reg_wdata}, 0);
        else begin
          logic [18:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk({reg_sel, reg_wdata} == e, t, {reg_sel, reg_wdata}, e);
        end
        if (reg_sel == 3'd0 && reg_wdata == 16'h0007) hold_start = cyc;
        if (reg_sel == 3'd0 && reg_wdata == 16'h0002)
          chk(cyc - hold_start == HOLD, "R8 hold length", cyc - hold_start, HOLD);
        if (reg_sel == 3'd1 && reg_wdata == 16'h0001) sec_seen++;
      end
      if (src_valid) src_valid = 1'b0;
      else if (src_req) begin
        if (lat) begin
          src_valid = 1'b1;
          src_word = mem[src_addr[9:2]];
          lat = 0;
        end else lat = 1;
      end
      rd_valid = rd_pend;
      if (rd_pend && sec_seen > 0)
        rd_data = sec_crc[sec_seen-1] ^ ((corrupt_sec == sec_seen - 1) ? 16'h0100 : 16'h0000);
      rd_pend = reg_rd;
      if (done) begin done_seen++; err_seen = err; end
    end
  end

  task automatic run(int dmo, int dmb, int imo, int imb, int corr, bit busy_start, string tag);
    int experr, offs[2], szs[2];
    logic [31:0] bases[2];
    logic [15:0] c;
    bit stop;
    expq.delete(); tagq.delete();
    offs[0] = dmo; offs[1] = imo; szs[0] = dmb; szs[1] = imb;
    bases[0] = 32'h3FFE_0000; bases[1] = 32'h4000_0000;
    experr = 0; stop = 0;
    for (int s = 0; s < 2; s++) begin
      c = 16'h0000;
      for (int k = 0; k < szs[s] / 4; k++) c = crc_bytes(c, mem[offs[s]/4 + k]);
      sec_crc[s] = c;
    end
    if (dmb % 4 != 0) experr = 1;
    else if (imb % 4 != 0) experr = 2;
    else begin
      push(3'd0, 16'h0003, "R3 stall write");
      for (int s = 0; s < 2 && !stop; s++) begin
        push(3'd1, 16'h0001, "R4 crc clear");
        push(3'd2, bases[s][31:16], "R4 addr high");
        push(3'd3, bases[s][15:0], "R4 addr low");
        for (int k = 0; k < szs[s] / 4; k++) begin
          push(3'd4, mem[offs[s]/4 + k][31:16], "R5 data high");
          push(3'd5, mem[offs[s]/4 + k][15:0], "R5 data low");
          push(3'd1, 16'h0006, "R5 execute");
        end
        if (corr == s) begin experr = 3 + s; stop = 1; end
      end
      if (!stop) begin
        push(3'd6, 16'h0000, "R7 clear global");
        push(3'd0, 16'h0007, "R7 reset hold");
        push(3'd0, 16'h0002, "R8 release");
      end
    end
    sec_seen = 0; corrupt_sec = corr; done_seen = 0;
    dm_offset = 24'(dmo); dm_bytes = 24'(dmb); im_offset = 24'(imo); im_bytes = 24'(imb);
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    if (busy_start) begin
      repeat (10) @(negedge clk);
      #1 dm_bytes = 24'd3; dm_offset = 24'h80; start = 1'b1;
      @(negedge clk); #1 start = 1'b0;
    end
    for (int i = 0; i < 6000 && done_seen == 0; i++) begin @(negedge clk); #1; end
    chk(done_seen == 1, {tag, " R9 done seen"}, done_seen, 1);
    chk(err_seen == 3'(experr), tag, err_seen, experr);
    @(negedge clk); #1;
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    repeat (5) begin @(negedge clk); #1; end
    chk(expq.size() == 0, {tag, " R6 all writes seen"}, expq.size(), 0);
    chk(done_seen == 1, {tag, " R10 single done"}, done_seen, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(reg_wr == 0 && reg_rd == 0 && src_req == 0, "R1 reset outputs", {reg_wr, reg_rd, src_req}, 0);
    chk(done == 0 && err == 0, "R1 reset done/err", {done, err}, 0);
    run(24'h40, 16, 24'h100, 24, -1, 0, "R9 success");
    run(24'h40, 6, 24'h100, 24, -1, 0, "R2 data unaligned");
    run(24'h40, 16, 24'h100, 22, -1, 0, "R2 instr unaligned");
    run(24'h40, 5, 24'h100, 7, -1, 0, "R2 both unaligned");
    run(24'h40, 16, 24'h100, 24, 0, 0, "R6 data crc fail");
    run(24'h20, 12, 24'h200, 20, 1, 0, "R6 instr crc fail");
    run(24'h10, 8, 24'h300, 0, -1, 0, "R11 empty instr");
    run(24'h10, 0, 24'h300, 8, -1, 0, "R11 empty data");
    run(24'h60, 20, 24'h180, 16, -1, 1, "R10 busy start");
    run(24'h00, 4, 24'h3FC, 4, -1, 0, "R9 restart");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule